// File: doc/BRIEF.md
# Dual-Mode Card Status and User Pin Controller

This block governs a small group of shared pins on a host-bus peripheral that can sit on either of two host buses. When the card-bus mode input is high, each general user pin can be switched between input and output by software, and one further pin carries an active-low status-change indication. When the mode input is low (legacy bus), every managed pin is left undriven so that the pad can deliver a bus address or control signal to other logic.

Software reaches the block through a small register port holding three registers: an enable register, a user-data register and a status-control register. Reads of the data positions return the live level seen at the pads, after a two-flop synchronizer, and not the last value written. The status-change output is gated by an unmask bit. Hardware clears that bit whenever the incoming wakeup status falls, so software must unmask it again for each new wakeup.

Top module: `pinmux_stat_ctrl`

## Requirements
- R1: After synchronous reset, every output enable is 0, the enable register reads 0, and the status-control register reads back its function bit as 0.
- R2: While `card_mode` is 0, one clock later no user pin and not the status pin has its output enable set, whatever the register contents are.
- R3: In card mode, one clock after the registers settle, user pin i has `user_pin_oe[i]` equal to enable bit i (address 0, bit i). When enabled, `user_pin_out[i]` equals data bit i (address 1, bit i). An undriven pin has `user_pin_out[i]` at 0.
- R4: Reading address 1 returns, in bit i, the pad level of user pin i after two synchronizer flops plus the read register, whatever was written. Bits above the pin count read 0.
- R5: In card mode with the function bit (address 2, bit 1) at 0, the status pin is driven, and its level is the inverse of the unmask bit (address 2, bit 0).
- R6: In card mode with the function bit at 1, the status pin is driven low only while the unmask bit and `wake_sts` are both 1. Otherwise it is driven high.
- R7: A 1-to-0 transition on `wake_sts` clears the unmask bit. If a register write setting the unmask bit lands in the same clock, the clear wins.
- R8: Reading address 2 returns, in bit 0, the inverse of the synchronized status pad level in every mode, and in bit 1 the function bit.
- R9: Reading address 0 returns the enable bits in bits 0 to NUM_USER-1 and 0 above. Writes to address 3 change no register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_mode | input | 1 | 1 selects card-bus mode, 0 selects legacy bus |
| wake_sts | input | 1 | Wakeup status from the configuration-status register |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 data, 2 status control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| user_pin_in | input | NUM_USER | Pad levels of the user pins |
| user_pin_oe | output | NUM_USER | Output enables of the user pins |
| user_pin_out | output | NUM_USER | Output values of the user pins |
| stat_pin_in | input | 1 | Pad level of the status-change pin |
| stat_pin_oe | output | 1 | Output enable of the status-change pin |
| stat_pin_out | output | 1 | Active-low status-change output value |

## Verification
On every cycle, assertions check that legacy mode releases all pins, that user drives follow the enable and data registers one clock later, that the status pin obeys the inverse-data and masked-wakeup rules, and that a falling wakeup leaves the unmask bit clear. Only the bench's scenarios can show what happens at the pads. This covers live readback against an external driver after the synchronizer delay, and the fact that a write-versus-clear collision is lost by software. It also covers that a later wakeup stays masked after an auto-clear, and that unmapped-address writes are harmless. The bench sweeps every enable and data pattern in both modes, with a modelled pad that resolves the drive against an external level.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE = 2'd0,
    RA_DATA   = 2'd1,
    RA_STAT   = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  localparam int STAT_UNMASK_BIT = 0;
  localparam int STAT_FUNC_BIT   = 1;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/user_pin_bank.sv
module user_pin_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         card_mode,
  input  logic         wr_enable,
  input  logic         wr_data,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_out
);
  logic [N-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      dat_q <= '0;
    end else begin
      if (wr_enable) en_q  <= wdata;
      if (wr_data)   dat_q <= wdata;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic drive;
    assign drive = card_mode & en_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[i]  <= 1'b0;
        pin_out[i] <= 1'b0;
      end else begin
        pin_oe[i]  <= drive;
        pin_out[i] <= drive & dat_q[i];
      end
    end
  end

  // R3
  user_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $past(card_mode) |-> (pin_oe == $past(en_q)) && (pin_out == ($past(en_q) & $past(dat_q))));
endmodule

// File: rtl/stschg_unit.sv
module stschg_unit (
  input  logic clk,
  input  logic rst,
  input  logic card_mode,
  input  logic wake_sts,
  input  logic wr_stat,
  input  logic wdata_unmask,
  input  logic wdata_func,
  output logic unmask_q,
  output logic func_q,
  output logic stat_oe,
  output logic stat_out
);
  logic wake_prev;
  logic wake_fall;
  logic next_level;

  assign wake_fall = wake_prev & ~wake_sts;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_prev <= 1'b0;
      unmask_q  <= 1'b0;
      func_q    <= 1'b0;
    end else begin
      wake_prev <= wake_sts;
      if (wr_stat) func_q <= wdata_func;
      if (wake_fall)    unmask_q <= 1'b0;
      else if (wr_stat) unmask_q <= wdata_unmask;
    end
  end

  always_comb begin
    if (func_q) next_level = ~(unmask_q & wake_sts);
    else        next_level = ~unmask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_oe  <= 1'b0;
      stat_out <= 1'b1;
    end else begin
      stat_oe  <= card_mode;
      stat_out <= next_level;
    end
  end

  // R7
  unmask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_prev && !wake_sts) |=> !unmask_q);

  // R6
  masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (card_mode && func_q && !unmask_q) |=> (stat_oe && stat_out));

  // R6
  wake_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (card_mode && func_q && unmask_q && wake_sts) |=> (stat_oe && !stat_out));

  // R5
  inverse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (card_mode && !func_q) |=> (stat_oe && (stat_out == !$past(unmask_q))));
endmodule

// File: rtl/pinmux_stat_ctrl.sv
module pinmux_stat_ctrl #(
  parameter int NUM_USER = 5,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          card_mode,
  input  logic                          wake_sts,
  input  logic                          reg_we,
  input  logic [pinmux_pkg::REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic [NUM_USER-1:0]           user_pin_in,
  output logic [NUM_USER-1:0]           user_pin_oe,
  output logic [NUM_USER-1:0]           user_pin_out,
  input  logic                          stat_pin_in,
  output logic                          stat_pin_oe,
  output logic                          stat_pin_out
);
  import pinmux_pkg::*;

  localparam int SYNC_W = NUM_USER + 1;

  logic                wr_enable, wr_data, wr_stat;
  logic [NUM_USER-1:0] en_q;
  logic                unmask_q, func_q;
  logic [SYNC_W-1:0]   pad_sync;
  logic [DATA_W-1:0]   rd_next;

  assign wr_enable = reg_we && (reg_addr == RA_ENABLE);
  assign wr_data   = reg_we && (reg_addr == RA_DATA);
  assign wr_stat   = reg_we && (reg_addr == RA_STAT);

  user_pin_bank #(.N(NUM_USER)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .card_mode (card_mode),
    .wr_enable (wr_enable),
    .wr_data   (wr_data),
    .wdata     (reg_wdata[NUM_USER-1:0]),
    .en_q      (en_q),
    .pin_oe    (user_pin_oe),
    .pin_out   (user_pin_out)
  );

  stschg_unit u_stat (
    .clk          (clk),
    .rst          (rst),
    .card_mode    (card_mode),
    .wake_sts     (wake_sts),
    .wr_stat      (wr_stat),
    .wdata_unmask (reg_wdata[STAT_UNMASK_BIT]),
    .wdata_func   (reg_wdata[STAT_FUNC_BIT]),
    .unmask_q     (unmask_q),
    .func_q       (func_q),
    .stat_oe      (stat_pin_oe),
    .stat_out     (stat_pin_out)
  );

  pin_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({stat_pin_in, user_pin_in}),
    .q   (pad_sync)
  );

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      RA_ENABLE: rd_next[NUM_USER-1:0] = en_q;
      RA_DATA:   rd_next[NUM_USER-1:0] = pad_sync[NUM_USER-1:0];
      RA_STAT: begin
        rd_next[STAT_UNMASK_BIT] = ~pad_sync[NUM_USER];
        rd_next[STAT_FUNC_BIT]   = func_q;
      end
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R2
  legacy_release_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(card_mode) |-> (user_pin_oe == '0) && !stat_pin_oe);

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (user_pin_oe == '0) && !stat_pin_oe && (reg_rdata == '0));

  // R8
  stat_func_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == RA_STAT) |-> (reg_rdata[STAT_FUNC_BIT] == $past(func_q)));
endmodule

// File: tb/tb_pinmux_stat_ctrl.sv
module tb_pinmux_stat_ctrl;
  localparam int NU = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          card_mode = 1'b0;
  logic          wake_sts = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NU-1:0] user_ext = '0;
  logic [NU-1:0] user_pad, user_oe, user_out;
  logic          stat_ext = 1'b1;
  logic          stat_pad, stat_oe, stat_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // pad model: the driver wins over the external level
  for (genvar i = 0; i < NU; i++) begin : g_pad
    assign user_pad[i] = user_oe[i] ? user_out[i] : user_ext[i];
  end
  assign stat_pad = stat_oe ? stat_out : stat_ext;

  pinmux_stat_ctrl #(.NUM_USER(NU), .DATA_W(DW)) dut (
    .clk          (clk),
    .rst          (rst),
    .card_mode    (card_mode),
    .wake_sts     (wake_sts),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .user_pin_in  (user_pad),
    .user_pin_oe  (user_oe),
    .user_pin_out (user_out),
    .stat_pin_in  (stat_pad),
    .stat_pin_oe  (stat_oe),
    .stat_pin_out (stat_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    repeat (4) @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    logic [NU-1:0] exp_pad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 user oe", user_oe, 0);
    chk("R1 stat oe", stat_oe, 0);
    rd(2'd0, r); chk("R1 enable read", r, 0);
    rd(2'd2, r); chk("R1 stat read", r, 0);

    // R2 R3 R4 R9: full sweep of enable and data in both modes
    for (int m = 0; m < 2; m++) begin
      card_mode = m[0];
      for (int e = 0; e < 32; e++) begin
        wr(2'd0, DW'(e));
        for (int d = 0; d < 32; d++) begin
          user_ext = NU'(d) ^ 5'h15;
          wr(2'd1, DW'(d | 8'he0));
          settle();
          if (m == 0) begin
            chk("R2 legacy user oe", user_oe, 0);
            chk("R2 legacy stat oe", stat_oe, 0);
          end else begin
            chk("R3 user oe", user_oe, e[NU-1:0]);
            chk("R3 user out", user_out, e[NU-1:0] & d[NU-1:0]);
          end
          for (int i = 0; i < NU; i++)
            exp_pad[i] = (m == 1 && e[i]) ? d[i] : user_ext[i];
          rd(2'd1, r);
          chk("R4 live readback", r, {3'b000, exp_pad});
        end
        rd(2'd0, r);
        chk("R9 enable readback", r, DW'(e));
      end
    end

    // R9: unmapped address
    wr(2'd0, 8'h0a);
    wr(2'd3, 8'hff);
    rd(2'd0, r); chk("R9 enable after addr3 write", r, 8'h0a);
    rd(2'd3, r); chk("R9 addr3 reads zero", r, 0);
    rd(2'd2, r); chk("R9 stat unchanged by addr3", r[1], 0);

    // R5 R8: inverse-data status pin
    card_mode = 1'b1;
    wake_sts = 1'b0;
    wr(2'd2, 8'h00); settle();
    chk("R5 stat oe", stat_oe, 1);
    chk("R5 stat out unmask0", stat_out, 1);
    rd(2'd2, r); chk("R8 stat read unmask0", r, 8'h00);
    wr(2'd2, 8'h01); settle();
    chk("R5 stat out unmask1", stat_out, 0);
    rd(2'd2, r); chk("R8 stat read unmask1", r, 8'h01);
    wake_sts = 1'b1;
    wr(2'd2, 8'h00); settle();
    chk("R5 wake ignored func0", stat_out, 1);
    wake_sts = 1'b0;
    settle();

    // R6: masked wakeup
    wr(2'd2, 8'h02);
    wake_sts = 1'b1; settle();
    chk("R6 masked wake", stat_out, 1);
    rd(2'd2, r); chk("R8 func read masked", r, 8'h02);
    wr(2'd2, 8'h03); settle();
    chk("R6 unmasked wake", stat_out, 0);
    rd(2'd2, r); chk("R8 func read asserted", r, 8'h03);

    // R7: falling wake clears unmask
    wake_sts = 1'b0; settle();
    chk("R6 no wake deasserted", stat_out, 1);
    wake_sts = 1'b1; settle();
    chk("R7 auto-clear masks next wake", stat_out, 1);

    // R7: clear wins over same-cycle set
    wr(2'd2, 8'h03); settle();
    chk("R7 rearmed", stat_out, 0);
    @(negedge clk);
    wake_sts = 1'b0; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h03;
    @(negedge clk);
    reg_we = 1'b0;
    wake_sts = 1'b1;
    settle();
    chk("R7 clear beats write", stat_out, 1);

    // R2 R8: legacy mode releases status pin, read follows pad
    card_mode = 1'b0;
    stat_ext = 1'b1; settle();
    chk("R2 legacy stat oe", stat_oe, 0);
    rd(2'd2, r); chk("R8 legacy pad high", r, 8'h02);
    stat_ext = 1'b0;
    rd(2'd2, r); chk("R8 legacy pad low", r, 8'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule